// File: doc/BRIEF.md
# Float-to-Signed-Integer Converter

This unit turns one IEEE-754 single-precision value into a two's-complement signed integer. The result is 32 or 64 bits wide, chosen per operation. A pipeline stage or execution slot presents an operand, a width select and rounding controls with a valid strobe. One clock later the unit returns the integer together with an invalid flag and an inexact flag.

A 2-bit global rounding mode normally governs the conversion. A per-operation override can replace it with a 2-bit rounding field carried by the operation, but only when the operand comes from a register. The unit does not saturate. Any input that cannot be represented in the chosen width, including every NaN and both infinities, yields a fixed sentinel pattern and sets the invalid flag. Decode, trapping and flag masking are left to the surrounding logic.

Top module: `fp2int_cvt`

## Requirements
- R1: Only `src[31:0]` is converted. The value of `src[63:32]` never changes any output.
- R2: With `wide`=1 the full 64-bit signed result is driven on `result`. With `wide`=0 the 32-bit signed result is driven on `result[31:0]` and `result[63:32]` is zero.
- R3: The rounding mode is encoded 00 = nearest with ties to even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero.
- R4: When `rc_ovr_en`=1 and `reg_src`=1, `rc_op` selects the rounding mode. In every other case `rc_glb` selects it and `rc_op` has no effect.
- R5: With `wide`=0, a rounded value outside [-2^31, 2^31-1] sets `invalid` and returns 0x0000_0000_8000_0000.
- R6: With `wide`=1, a rounded value outside [-2^63, 2^63-1] sets `invalid` and returns 0x8000_0000_0000_0000.
- R7: Any NaN (exponent field all ones, nonzero fraction) and either infinity set `invalid` and return the sentinel pattern for the selected width.
- R8: `inexact` is set exactly when the rounded result differs from the input value. It is never set together with `invalid`.
- R9: +0 and -0 give result 0 with both flags clear.
- R10: Denormals and other values of magnitude below 1 give 0, +1 or -1 according to the rounding mode. They set `inexact` whenever they are nonzero.
- R11: Exactly -2^31 with `wide`=0 and exactly -2^63 with `wide`=1 are in range. They return that value with no flag set.
- R12: `out_valid` equals `in_valid` delayed by one clock. Results and flags appear in that same cycle. Reset clears `out_valid`, `result` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 64 | Source operand; the low 32 bits hold the float |
| wide | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| rc_glb | input | 2 | Global rounding mode |
| rc_ovr_en | input | 1 | Request to use the per-operation rounding field |
| reg_src | input | 1 | Operand comes from a register (override is allowed) |
| rc_op | input | 2 | Per-operation rounding field |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Signed integer result |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Precision (inexact) flag |

## Verification
All results share one register stage. The integer, both flags and `out_valid` are all due in the first clock after the operation is strobed. The bench computes its expectation from the inputs when it drives them, pushes that expectation onto a queue and drives on falling edges. At the next falling edge it pops the queue and compares every output. Cycles without a strobe are checked for `out_valid` low, which pins the latency to exactly one cycle.

// File: rtl/fp2int_cvt.sv
module fp2int_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] src,
  input  logic        wide,
  input  logic [1:0]  rc_glb,
  input  logic        rc_ovr_en,
  input  logic        reg_src,
  input  logic [1:0]  rc_op,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        invalid,
  output logic        inexact
);

  localparam logic [63:0] INDEF64 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] INDEF32 = 64'h0000_0000_8000_0000;

  logic [31:0] f;
  logic        sgn, special, big, rbit, sticky, up, ovf, inv_c, inx_c;
  logic [7:0]  ex, ee, lsh, rsh, eu, lim;
  logic [4:0]  sc;
  logic [22:0] fr;
  logic [23:0] m, ip;
  logic [48:0] shr;
  logic [63:0] mag, sv, res_c;
  logic [1:0]  rc;
  logic        wide_q;

  assign f       = src[31:0];
  assign sgn     = f[31];
  assign ex      = f[30:23];
  assign fr      = f[22:0];
  assign special = (ex == 8'hff);
  assign ee      = (ex == 8'd0) ? 8'd1 : ex;
  assign m       = {ex != 8'd0, fr};
  assign big     = (ee >= 8'd150);
  assign lsh     = ee - 8'd150;
  assign rsh     = 8'd150 - ee;
  assign sc      = (rsh > 8'd25) ? 5'd25 : rsh[4:0];
  assign shr     = {m, 25'b0} >> sc;
  assign ip      = shr[48:25];
  assign rbit    = shr[24];
  assign sticky  = |shr[23:0];
  assign rc      = (rc_ovr_en && reg_src) ? rc_op : rc_glb;

  always_comb begin
    case (rc)
      2'b00:   up = rbit & (sticky | ip[0]);
      2'b01:   up = sgn & (rbit | sticky);
      2'b10:   up = ~sgn & (rbit | sticky);
      default: up = 1'b0;
    endcase
  end

  assign mag   = big ? ({40'b0, m} << lsh) : {39'b0, {1'b0, ip} + {24'b0, up}};
  assign eu    = ex - 8'd127;
  assign lim   = wide ? 8'd63 : 8'd31;
  assign ovf   = (ex >= 8'd127) && ((eu > lim) || ((eu == lim) && !(sgn && fr == 23'd0)));
  assign inv_c = special | ovf;
  assign inx_c = ~inv_c & ~big & (rbit | sticky);
  assign sv    = sgn ? (64'd0 - mag) : mag;
  assign res_c = inv_c ? (wide ? INDEF64 : INDEF32)
                       : (wide ? sv : {32'b0, sv[31:0]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 64'd0;
      invalid   <= 1'b0;
      inexact   <= 1'b0;
      wide_q    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_c;
        invalid <= inv_c;
        inexact <= inx_c;
        wide_q  <= wide;
      end
    end
  end

  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(invalid && inexact));
  assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> (result[63:32] == 32'd0));
  assert_indef64_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid && wide_q) |-> (result == INDEF64));
  assert_indef32_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid && !wide_q) |-> (result == INDEF32));
  assert_special_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src[30:23] == 8'hff) |=> invalid);

endmodule

// File: tb/sim_fp2int_cvt.sv
`timescale 1ns/1ps
module sim_fp2int_cvt;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, wide = 0, rc_ovr_en = 0, reg_src = 0;
  logic [63:0] src = 0;
  logic [1:0]  rc_glb = 0, rc_op = 0;
  logic        out_valid, invalid, inexact;
  logic [63:0] result;

  int checks = 0, errors = 0;
  logic [63:0] q_res[$];
  bit          q_inv[$], q_inx[$];
  string       q_tag[$];
  bit          exp_valid = 0;

  always #4 clk = ~clk;

  fp2int_cvt u0 (.clk, .rst_n, .in_valid, .src, .wide, .rc_glb, .rc_ovr_en,
                 .reg_src, .rc_op, .out_valid, .result, .invalid, .inexact);

  function automatic void model(input logic [31:0] f, input bit w, input logic [1:0] rc,
                                output logic [63:0] r, output bit inv, output bit inx);
    bit s = f[31];
    int e = f[30:23];
    logic [63:0] m = {40'd0, (e != 0), f[22:0]};
    logic [63:0] mag = 0, lmt, q, rem, half;
    bit lt = 0, eq = 0, nz = 0, up = 0;
    int ee = (e == 0) ? 1 : e;
    inv = 0; inx = 0;
    if (e == 255) inv = 1;
    else if (m == 0) mag = 0;
    else if (ee >= 150) begin
      if (ee - 150 > 40) inv = 1;
      else begin
        mag = m << (ee - 150);
        lmt = w ? (64'd1 << 63) : (64'd1 << 31);
        if (mag > lmt || (mag == lmt && !s)) inv = 1;
      end
    end else begin
      int sh = 150 - ee;
      if (sh > 40) begin q = 0; lt = 1; eq = 0; nz = 1; end
      else begin
        q = m >> sh; rem = m - (q << sh); half = 64'd1 << (sh - 1);
        nz = rem != 0; lt = rem < half; eq = rem == half;
      end
      case (rc)
        2'b00: up = nz && !lt && (!eq || q[0]);
        2'b01: up = nz && s;
        2'b10: up = nz && !s;
        default: up = 0;
      endcase
      mag = q + up; inx = nz;
    end
    if (inv) begin r = w ? 64'h8000_0000_0000_0000 : 64'h8000_0000; inx = 0; end
    else begin
      r = s ? -mag : mag;
      if (!w) r = {32'd0, r[31:0]};
    end
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid) begin
      errors++; $display("FAIL R12 out_valid actual %0b expected %0b", out_valid, exp_valid);
    end else if (exp_valid) begin
      logic [63:0] er = q_res.pop_front();
      bit ei = q_inv.pop_front(), ex = q_inx.pop_front();
      string t = q_tag.pop_front();
      if (result !== er || invalid !== ei || inexact !== ex) begin
        errors++;
        $display("FAIL %s actual %h/%0b/%0b expected %h/%0b/%0b", t, result, invalid, inexact, er, ei, ex);
      end
    end
  endtask

  task automatic op(input bit v, input logic [63:0] s, input bit w, input logic [1:0] g,
                    input bit oe, input bit rs, input logic [1:0] ro, input string tag);
    logic [63:0] r; bit i, x;
    @(negedge clk);
    compare();
    in_valid = v; src = s; wide = w; rc_glb = g; rc_ovr_en = oe; reg_src = rs; rc_op = ro;
    exp_valid = v;
    if (v) begin
      model(s[31:0], w, (oe && rs) ? ro : g, r, i, x);
      q_res.push_back(r); q_inv.push_back(i); q_inx.push_back(x); q_tag.push_back(tag);
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (out_valid !== 0 || result !== 0 || invalid !== 0 || inexact !== 0) begin
      errors++; $display("FAIL R12 reset state actual %0b %h %0b %0b expected 0", out_valid, result, invalid, inexact);
    end
    op(1, 64'h3FC00000, 1, 2'b00, 0, 0, 0, "R3 1.5 nearest");
    op(1, 64'h40200000, 1, 2'b00, 0, 0, 0, "R3 2.5 ties even");
    op(1, 64'h40600000, 0, 2'b00, 0, 0, 0, "R3 3.5 ties even");
    op(1, 64'hC0200000, 1, 2'b01, 0, 0, 0, "R3 -2.5 down");
    op(1, 64'hC0200000, 1, 2'b10, 0, 0, 0, "R3 -2.5 up");
    op(1, 64'h402CCCCD, 0, 2'b11, 0, 0, 0, "R3 2.7 zero");
    op(1, 64'h3FC00000, 1, 2'b11, 1, 1, 2'b10, "R4 override used");
    op(1, 64'h3FC00000, 1, 2'b11, 1, 0, 2'b10, "R4 memory source ignores field");
    op(1, 64'h3FC00000, 1, 2'b11, 0, 1, 2'b10, "R4 override off");
    op(1, 64'hDEAD_BEEF_3FC00000, 1, 2'b00, 0, 0, 0, "R1 upper bits");
    op(1, 64'h4F000000, 0, 2'b00, 0, 0, 0, "R5 2^31 narrow");
    op(1, 64'h4F000000, 1, 2'b00, 0, 0, 0, "R2 2^31 wide");
    op(1, 64'hCF000000, 0, 2'b00, 0, 0, 0, "R11 -2^31 narrow");
    op(1, 64'hCF000001, 0, 2'b00, 0, 0, 0, "R5 below -2^31");
    op(1, 64'h5F000000, 1, 2'b00, 0, 0, 0, "R6 2^63 wide");
    op(1, 64'hDF000000, 1, 2'b00, 0, 0, 0, "R11 -2^63 wide");
    op(1, 64'hE0000000, 1, 2'b00, 0, 0, 0, "R6 -2^65");
    op(1, 64'h7FC00000, 1, 2'b00, 0, 0, 0, "R7 quiet NaN");
    op(1, 64'h7F800001, 0, 2'b00, 0, 0, 0, "R7 signalling NaN");
    op(1, 64'hFF800000, 0, 2'b00, 0, 0, 0, "R7 minus inf");
    op(1, 64'h7F800000, 1, 2'b00, 0, 0, 0, "R7 plus inf");
    op(1, 64'h00000000, 1, 2'b10, 0, 0, 0, "R9 plus zero");
    op(1, 64'h80000000, 0, 2'b01, 0, 0, 0, "R9 minus zero");
    op(1, 64'h00000001, 1, 2'b10, 0, 0, 0, "R10 denormal up");
    op(1, 64'h80000001, 0, 2'b01, 0, 0, 0, "R10 denormal down");
    op(1, 64'h3F000000, 1, 2'b00, 0, 0, 0, "R10 half nearest");
    op(1, 64'hBF400000, 1, 2'b00, 0, 0, 0, "R10 -0.75 nearest");
    op(1, 64'h4B000001, 1, 2'b00, 0, 0, 0, "R8 exact integer");
    op(0, 0, 0, 0, 0, 0, 0, "R12 idle");
    op(0, 0, 0, 0, 0, 0, 0, "R12 idle");
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] s = {$urandom, $urandom};
      if (k % 3 == 0) s[30:23] = 8'd110 + 8'($urandom % 90);
      op(($urandom % 5) != 0, s, 1'($urandom), 2'($urandom), 1'($urandom),
         1'($urandom), 2'($urandom), "R2 R3 R4 R8 random");
    end
    op(0, 0, 0, 0, 0, 0, 0, "R12 drain");
    @(negedge clk);
    compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule